// File: doc/BRIEF.md
# I2C Slave Front End for an Eight-Bit Port Expander

This block sits between an I2C bus and a four-entry register file of a general-purpose I/O expander. It watches oversampled copies of SCL and SDA. It answers to a 7-bit device address, and on SDA it drives only an open-drain pull-down enable. The address is made of a fixed four-bit prefix (binary 0100) followed by three bits taken from strap inputs.

After its address arrives with the write direction, the block takes a command byte that picks one of the registers. Any further bytes in the same write are handed to the register file as write strobes, together with the register index and the data byte.

A register is read in three steps: a write that carries the command byte, a repeated START, and then the address with the read direction. The block then sends the selected register byte after byte while the master acknowledges. The index never advances. Each byte is fetched afresh with its own read strobe, so an input port that changes between bytes shows up in the bytes that follow.

Top module: `gpx_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits equal {0100, strap[2:0]} is acknowledged: sda_pull is high during the ninth SCL clock.
- R2: An address byte that does not match is not acknowledged. Every later byte up to the next START or STOP gets no acknowledge and produces no strobe.
- R3: A command byte with value 0 to 3 is acknowledged and becomes reg_idx. A command byte of 4 or more is not acknowledged, leaves reg_idx unchanged, and makes the slave ignore the bus until the next START or STOP.
- R4: Each data byte that follows an accepted command in a write is acknowledged. It produces a one-cycle reg_wr pulse with wdata equal to the byte and reg_idx unchanged, so repeated bytes all go to the same register.
- R5: After an address with R/W=1, the slave shifts out rdata MSB first. It samples rdata in the cycle of a one-cycle reg_rd pulse, and this happens once per byte.
- R6: Consecutive read bytes use the same reg_idx. Each byte reflects rdata at the moment that byte is loaded, so a changing input port gives differing bytes.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more, with no further reg_rd pulse, until the next START or STOP.
- R8: A START received in the middle of a byte clears the bit counter and restarts address reception. A STOP received in the middle of a byte discards the partial byte without a strobe.
- R9: sda_pull is asserted only while SCL is low. Input bits are sampled on SCL rising edges.
- R10: While rst is high, sda_pull, reg_rd and reg_wr are low. The state after reset is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level as seen at the pin |
| sda_in | input | 1 | Bus data level as seen at the pin |
| strap | input | 3 | Low address bits set by board straps |
| rdata | input | 8 | Contents of the register selected by reg_idx |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| reg_idx | output | 2 | Selected register: 0 input, 1 output, 2 polarity, 3 configuration |
| reg_rd | output | 1 | One-cycle pulse when a read byte is loaded |
| reg_wr | output | 1 | One-cycle pulse when a write byte is complete |
| wdata | output | 8 | Byte to be written, valid with reg_wr |

## Verification
Two things can land in the same clock cycle: loading a fresh read byte from rdata, and the register file changing the input port value. The bench provokes this by changing the port value during the acknowledge clock of each read byte. It then expects every following byte to carry the newer value and expects one reg_rd pulse per byte. The same goes for a START or STOP that cuts a byte short while the bit counter is mid-count. The bench judges that case by whether the next address is acknowledged and by the absence of any write strobe for the partial byte.

// File: rtl/gpx_i2c_pkg.sv
package gpx_i2c_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } link_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic is_ack_phase(link_state_e s);
        return (s == ST_ADDR_ACK) || (s == ST_CMD_ACK) ||
               (s == ST_WDAT_ACK) || (s == ST_TX_ACK);
    endfunction

endpackage

// File: rtl/gpx_bus_sampler.sv
module gpx_bus_sampler
    import gpx_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [SYNC_STAGES:0] scl_q;
    logic [SYNC_STAGES:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-1:0], scl_in};
            sda_q <= {sda_q[SYNC_STAGES-1:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_q[SYNC_STAGES-1];
    assign scl_old = scl_q[SYNC_STAGES];
    assign sda_now = sda_q[SYNC_STAGES-1];
    assign sda_old = sda_q[SYNC_STAGES];

    always_comb begin
        evt.scl   = scl_now;
        evt.sda   = sda_now;
        evt.rise  = scl_now & ~scl_old;
        evt.fall  = ~scl_now & scl_old;
        evt.start = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop  = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/gpx_rx_shifter.sv
module gpx_rx_shifter #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [W-1:0]  data,
    output logic [CW-1:0] cnt,
    output logic          full
);

    assign full = (cnt == CW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (shift_en) begin
            data <= {data[W-2:0], bit_in};
            if (!full) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/gpx_i2c_slave.sv
module gpx_i2c_slave
    import gpx_i2c_pkg::*;
#(
    parameter int STRAP_W     = 3,
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter logic [BYTE_W-2-STRAP_W:0] ADDR_PREFIX = 4'b0100,
    localparam int IDX_W      = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rdata,
    output logic               sda_pull,
    output logic [IDX_W-1:0]   reg_idx,
    output logic               reg_rd,
    output logic               reg_wr,
    output logic [BYTE_W-1:0]  wdata
);

    localparam logic [BYTE_W-1:0] CMD_LIMIT = BYTE_W'(NUM_REGS);

    bus_evt_t              evt;
    link_state_e           state;
    logic [BYTE_W-1:0]     shreg;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic                  full;
    logic                  cnt_clr;
    logic [BYTE_W-1:0]     txreg;
    logic                  rw_bit;
    logic                  mack;
    logic [BYTE_W-2:0]     my_addr;

    assign my_addr = {ADDR_PREFIX, strap};
    assign cnt_clr = evt.start | evt.stop | (evt.fall & (full | is_ack_phase(state)));

    gpx_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    gpx_rx_shifter #(.W(BYTE_W), .CW(BIT_CNT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .shift_en (evt.rise),
        .bit_in   (evt.sda),
        .data     (shreg),
        .cnt      (bit_cnt),
        .full     (full)
    );

    always_ff @(posedge clk) begin
        reg_wr <= 1'b0;
        reg_rd <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
            reg_idx  <= '0;
            wdata    <= '0;
            txreg    <= '0;
            rw_bit   <= 1'b0;
            mack     <= 1'b0;
        end else if (evt.start) begin
            state    <= ST_ADDR;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (evt.fall && full) begin
                    if (shreg[BYTE_W-1:1] == my_addr) begin
                        rw_bit   <= shreg[0];
                        sda_pull <= 1'b1;
                        state    <= ST_ADDR_ACK;
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_ADDR_ACK: if (evt.fall) begin
                    if (rw_bit) begin
                        txreg    <= rdata;
                        reg_rd   <= 1'b1;
                        sda_pull <= ~rdata[BYTE_W-1];
                        state    <= ST_TX;
                    end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_CMD;
                    end
                end
                ST_CMD: if (evt.fall && full) begin
                    if (shreg < CMD_LIMIT) begin
                        reg_idx  <= shreg[IDX_W-1:0];
                        sda_pull <= 1'b1;
                        state    <= ST_CMD_ACK;
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_CMD_ACK, ST_WDAT_ACK: if (evt.fall) begin
                    sda_pull <= 1'b0;
                    state    <= ST_WDAT;
                end
                ST_WDAT: if (evt.fall && full) begin
                    wdata    <= shreg;
                    reg_wr   <= 1'b1;
                    sda_pull <= 1'b1;
                    state    <= ST_WDAT_ACK;
                end
                ST_TX: if (evt.fall) begin
                    if (full) begin
                        sda_pull <= 1'b0;
                        state    <= ST_TX_ACK;
                    end else begin
                        txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~txreg[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (evt.rise) mack <= ~evt.sda;
                    if (evt.fall) begin
                        if (mack) begin
                            txreg    <= rdata;
                            reg_rd   <= 1'b1;
                            sda_pull <= ~rdata[BYTE_W-1];
                            state    <= ST_TX;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9
    pull_only_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull && !$stable(sda_pull)) |-> !evt.scl);

    // R8
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (bit_cnt == '0 && !sda_pull && state == ST_ADDR));

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (!reg_rd && state == ST_TX));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_rd, reg_wr}));

    // R7
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_pull && !reg_rd && !reg_wr));

endmodule

// File: tb/gpx_i2c_slave_test.sv
module gpx_i2c_slave_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic [7:0] rdata;
    logic       sda_bus;
    logic       sda_pull, reg_rd, reg_wr;
    logic [1:0] reg_idx;
    logic [7:0] wdata;

    logic [7:0] port_in = 8'h00;
    logic [7:0] model [4];
    int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, r9_bad = 0;
    logic [1:0] last_idx = 2'd0;
    logic [7:0] last_dat = 8'h00;
    logic prev_pull = 1'b0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;
    always_comb rdata = (reg_idx == 2'd0) ? port_in : model[reg_idx];

    gpx_i2c_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .strap(strap),
        .rdata(rdata), .sda_pull(sda_pull), .reg_idx(reg_idx), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .wdata(wdata)
    );

    always @(negedge clk) begin
        if (reg_wr) begin
            wr_cnt++;
            last_idx = reg_idx;
            last_dat = wdata;
            if (reg_idx != 2'd0) model[reg_idx] = wdata;
        end
        if (reg_rd) rd_cnt++;
        if (sda_pull && !prev_pull && scl_m) r9_bad++;
        prev_pull = sda_pull;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(2);
        scl_m = 1'b1; cyc(3);
        sda_m = 1'b0; cyc(3);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(3);
        scl_m = 1'b1; cyc(3);
        sda_m = 1'b1; cyc(3);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b;    cyc(3);
        scl_m = 1'b1; cyc(2);
        r = sda_bus;  cyc(3);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, input logic [7:0] next_port,
                             output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        port_in = next_port;
        clk_bit(~give_ack, r);
    endtask

    function automatic logic [7:0] abyte(logic [2:0] s, logic rd);
        return {4'b0100, s, rd};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic r;
        logic [7:0] v;
        int base;
        for (int i = 0; i < 4; i++) model[i] = 8'h00;

        // R10: reset state
        cyc(5);
        check("R10 sda_pull", 32'(sda_pull), 0);
        check("R10 reg_rd", 32'(reg_rd), 0);
        check("R10 reg_wr", 32'(reg_wr), 0);
        rst = 1'b0;
        cyc(5);

        // R1: every strap value
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            bus_start();
            send_byte(abyte(3'(s), 1'b0), ack);
            check("R1 address ack", 32'(ack), 1);
            bus_stop();
        end

        // R2: full address sweep with one strap setting
        strap = 3'd5;
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            check("R2 address match", 32'(ack), 32'(a == 7'b0100101));
            if (a != 7'b0100101) begin
                send_byte(8'h01, ack);
                check("R2 ignored byte", 32'(ack), 0);
            end
            bus_stop();
        end
        check("R2 no writes", 32'(wr_cnt), 0);

        // R3 and R4: command sweep, each followed by one data byte
        for (int c = 0; c < 256; c++) begin
            base = wr_cnt;
            bus_start();
            send_byte(abyte(3'd5, 1'b0), ack);
            send_byte(8'(c), ack);
            check("R3 command ack", 32'(ack), 32'(c < 4));
            send_byte(8'(c) ^ 8'h5A, ack);
            check("R4 data ack", 32'(ack), 32'(c < 4));
            bus_stop();
            if (c < 4) begin
                check("R4 write count", 32'(wr_cnt), 32'(base + 1));
                check("R4 write index", 32'(last_idx), 32'(c));
                check("R4 write data", 32'(last_dat), 32'(8'(c) ^ 8'h5A));
            end else begin
                check("R3 rejected no write", 32'(wr_cnt), 32'(base));
            end
        end

        // R3: rejected command keeps previous index
        bus_start(); send_byte(abyte(3'd5, 1'b0), ack); send_byte(8'd2, ack); bus_stop();
        bus_start(); send_byte(abyte(3'd5, 1'b0), ack); send_byte(8'd9, ack); bus_stop();
        check("R3 index kept", 32'(reg_idx), 2);
        bus_start();
        send_byte(abyte(3'd5, 1'b1), ack);
        recv_byte(1'b0, port_in, v);
        bus_stop();
        check("R3 read after reject", 32'(v), 32'(8'd2 ^ 8'h5A));

        // R4: several bytes go to one register
        base = wr_cnt;
        bus_start();
        send_byte(abyte(3'd5, 1'b0), ack);
        send_byte(8'd1, ack);
        send_byte(8'h11, ack); check("R4 burst ack 1", 32'(ack), 1);
        send_byte(8'h22, ack); check("R4 burst ack 2", 32'(ack), 1);
        send_byte(8'h33, ack); check("R4 burst ack 3", 32'(ack), 1);
        bus_stop();
        check("R4 burst count", 32'(wr_cnt), 32'(base + 3));
        check("R4 burst index", 32'(last_idx), 1);

        // R6: repeated-start read of a stored register, no increment
        base = rd_cnt;
        bus_start();
        send_byte(abyte(3'd5, 1'b0), ack);
        send_byte(8'd1, ack);
        bus_start();
        send_byte(abyte(3'd5, 1'b1), ack);
        check("R5 read address ack", 32'(ack), 1);
        recv_byte(1'b1, port_in, v); check("R6 byte 1", 32'(v), 32'h33);
        recv_byte(1'b0, port_in, v); check("R6 byte 2", 32'(v), 32'h33);
        bus_stop();
        check("R6 index fixed", 32'(reg_idx), 1);
        check("R5 strobe per byte", 32'(rd_cnt), 32'(base + 2));

        // R5, R6, R7: input port changing between bytes
        port_in = 8'h5A;
        base = rd_cnt;
        bus_start();
        send_byte(abyte(3'd5, 1'b0), ack);
        send_byte(8'd0, ack);
        bus_start();
        send_byte(abyte(3'd5, 1'b1), ack);
        recv_byte(1'b1, 8'hC3, v); check("R5 port byte 1", 32'(v), 32'h5A);
        recv_byte(1'b1, 8'h0F, v); check("R6 port byte 2", 32'(v), 32'hC3);
        recv_byte(1'b1, 8'hF0, v); check("R6 port byte 3", 32'(v), 32'h0F);
        recv_byte(1'b0, 8'h00, v); check("R6 port byte 4", 32'(v), 32'hF0);
        check("R5 port strobes", 32'(rd_cnt), 32'(base + 4));
        recv_byte(1'b0, 8'h00, v);
        check("R7 released after nack", 32'(v), 32'hFF);
        check("R7 no strobe after nack", 32'(rd_cnt), 32'(base + 4));
        bus_stop();

        // R8: START and STOP inside a byte
        base = wr_cnt;
        bus_start();
        clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b0, r);
        bus_start();
        send_byte(abyte(3'd5, 1'b0), ack);
        check("R8 ack after mid-byte start", 32'(ack), 1);
        send_byte(8'd3, ack);
        check("R8 command after restart", 32'(ack), 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, r);
        bus_stop();
        check("R8 partial byte dropped", 32'(wr_cnt), 32'(base));
        bus_start();
        send_byte(abyte(3'd5, 1'b0), ack);
        check("R8 ack after mid-byte stop", 32'(ack), 1);
        bus_stop();

        // R9: pull-down never raised while SCL high
        check("R9 pull timing", 32'(r9_bad), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule